// File: doc/BRIEF.md
# Cache performance counter unit

This block counts cache events for one cluster. It holds a bank of 32-bit general event counters and one 64-bit cycle counter. All of its state sits behind a two-step window. Software first loads a 12-bit register address into the select register. It then writes that register through the data port, or reads it from the read-data port. The read-data port follows the selected register with no further delay.

Events enter as a flat grid of single-cycle pulses. The grid is ordered by group, and within each group by code, so the pulse for group g and code c sits at bit `g*2^CODE_W + c`. A shared selection register chooses one active code per group. Each general counter names the group it follows, and it counts the pulses of the code selected for that group.

Three bitmaps control the counters: counter enable, interrupt enable and overflow status. Each bitmap is reached through a set address and a clear address. When a counter wraps, its overflow bit is set. One level interrupt stays high while any overflow bit is also interrupt-enabled.

Top module: `cache_pmu`

## Requirements
- R1: After reset, every bitmap, counter value, configuration register and the selection register read zero. The interrupt is low, and the global control register reads only the counter-count field.
- R2: Writing the data port with `acc_wr_en` updates the register whose address was last loaded through `acc_sel_we`. `acc_rdata` shows that register's value from the cycle after the select load. Addresses that hold no register read as zero, and writes to them have no effect.
- R3: The global control register is at 0x400. Bit 0 is the global count enable, and every write to this register updates it. A write with bit 1 set zeroes all general counters, and a write with bit 2 set zeroes the cycle counter, so a write of 0x6 zeroes both. Bits 15:11 read back the number of general counters, NUM_CTR.
- R4: The bitmaps use these address pairs (clear, set): counter enable 0x403/0x404, interrupt enable 0x405/0x406, and overflow status 0x407/0x408. A 1 written to a set address sets that bit, a 1 written to a clear address clears it, and a 0 bit leaves it unchanged. Both addresses of a pair read the current bitmap. Bits of counters that are not present always read zero.
- R5: In every bitmap, general counter i owns bit i and the cycle counter owns bit 31.
- R6: General counter i increments by one on a clock edge only if four conditions hold together: the global enable is set, its counter-enable bit is set, bit 63 of the selection register is set, and the event pulse is high at index type*2^CODE_W + code, where type is the counter's group and code is the field selected for that group. A counter whose type is NUM_GROUPS or above never counts.
- R7: The 64-bit selection register is at 0x410. Group g takes its code from bits 8g+7:8g. Bit 63 is both the selection enable and the top code bit of group 7.
- R8: Counter i has four registers at 0x420+0x10*i plus an offset: control at +0, value at +1, filter at +3, and type at +4. Type is a 4-bit field. Control and filter are 32-bit stored values that do not affect counting.
- R9: The cycle counter value is a 64-bit register at 0x40A, and its 32-bit control register is at 0x409. The cycle counter increments on every edge where the global enable and bitmap bit 31 are both set.
- R10: When a general counter steps from 0xFFFFFFFF to 0, or the cycle counter steps from all-ones to 0, its overflow bit is set. If an overflow and an overflow-clear write happen in the same cycle, the overflow wins.
- R11: `pmu_irq` is high exactly while (overflow status AND interrupt enable) is nonzero.
- R12: When a value write and an increment of the same counter fall in the same cycle, the counter takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_sel_we | input | 1 | Load the select register |
| acc_sel_addr | input | 12 | Register address to select |
| acc_wr_en | input | 1 | Write the selected register |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Value of the selected register |
| evt_pulse | input | NUM_GROUPS*2^CODE_W | Event pulses, group-major grid |
| pmu_irq | output | 1 | Level overflow interrupt |

## Verification
A wrong selection field, group type or enable gate shows up at the ports as a counter value that differs from the number of matching pulses, as soon as the next read. A missed wrap shows as a clear overflow bitmap, and as an interrupt that stays low on the edge after the counter passes zero. A wrong bitmap mask shows in one read of the set or clear address. A reversed write/increment priority shows as a value that is off by one.

// File: rtl/cpmu_pkg.sv
package cpmu_pkg;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 64;
  localparam int MAP_W   = 32;
  localparam int CNT_W   = 32;
  localparam int CYC_W   = 64;
  localparam int GRP_W   = 4;
  localparam int GRP_PAD = 1 << GRP_W;
  localparam int CYC_BIT = 31;

  localparam logic [ADDR_W-1:0] A_CTRL    = 12'h400;
  localparam logic [ADDR_W-1:0] A_CEN_CLR = 12'h403;
  localparam logic [ADDR_W-1:0] A_CEN_SET = 12'h404;
  localparam logic [ADDR_W-1:0] A_IEN_CLR = 12'h405;
  localparam logic [ADDR_W-1:0] A_IEN_SET = 12'h406;
  localparam logic [ADDR_W-1:0] A_OVF_CLR = 12'h407;
  localparam logic [ADDR_W-1:0] A_OVF_SET = 12'h408;
  localparam logic [ADDR_W-1:0] A_CYC_CTL = 12'h409;
  localparam logic [ADDR_W-1:0] A_CYC_VAL = 12'h40A;
  localparam logic [ADDR_W-1:0] A_EVSEL   = 12'h410;
  localparam logic [7:0]        A_CTR_PG0 = 8'h42;

  localparam logic [3:0] O_CTL = 4'h0;
  localparam logic [3:0] O_VAL = 4'h1;
  localparam logic [3:0] O_FLT = 4'h3;
  localparam logic [3:0] O_TYP = 4'h4;

  function automatic logic [MAP_W-1:0] present_mask(input int n);
    logic [MAP_W-1:0] m;
    m = '0;
    for (int k = 0; k < MAP_W; k++) if (k < n) m[k] = 1'b1;
    m[CYC_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/cpmu_bitmap.sv
module cpmu_bitmap
  import cpmu_pkg::*;
#(
  parameter logic [MAP_W-1:0] MASK = 32'h8000_00FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [MAP_W-1:0] wdata,
  input  logic [MAP_W-1:0] hw_set,
  output logic [MAP_W-1:0] q
);
  logic [MAP_W-1:0] q_d;
  logic             q_ce;

  always_comb begin
    q_d  = ((q | (set_we ? wdata : '0)) & ~(clr_we ? wdata : '0)) | hw_set;
    q_d  = q_d & MASK;
    q_ce = set_we | clr_we | (|hw_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_ce) q <= q_d;
  end

  assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((q & $past(wdata & MASK)) == $past(wdata & MASK)));
  assert_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && hw_set == '0) |=> ((q & $past(wdata)) == '0));
  assert_ovf_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((q & $past(hw_set & MASK)) == $past(hw_set & MASK)));
endmodule

// File: rtl/cpmu_evt_ctr.sv
module cpmu_evt_ctr
  import cpmu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [3:0]         wr_off,
  input  logic [CNT_W-1:0]   wdata,
  input  logic               clr,
  input  logic               run,
  input  logic [GRP_PAD-1:0] grp_hit,
  output logic [CNT_W-1:0]   cnt_q,
  output logic [CNT_W-1:0]   ctl_q,
  output logic [CNT_W-1:0]   flt_q,
  output logic [GRP_W-1:0]   typ_q,
  output logic               wrap
);
  logic             wr_val, wr_ctl, wr_flt, wr_typ, inc, cnt_ce;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    wr_val = wr_en && (wr_off == O_VAL);
    wr_ctl = wr_en && (wr_off == O_CTL);
    wr_flt = wr_en && (wr_off == O_FLT);
    wr_typ = wr_en && (wr_off == O_TYP);
    inc    = run && grp_hit[typ_q];
    cnt_d  = cnt_q;
    if (clr)         cnt_d = '0;
    else if (wr_val) cnt_d = wdata;
    else if (inc)    cnt_d = cnt_q + 1'b1;
    cnt_ce = clr | wr_val | inc;
    wrap   = inc && !clr && !wr_val && (&cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ctl_q <= '0;
      flt_q <= '0;
      typ_q <= '0;
    end else begin
      if (cnt_ce) cnt_q <= cnt_d;
      if (wr_ctl) ctl_q <= wdata;
      if (wr_flt) flt_q <= wdata;
      if (wr_typ) typ_q <= wdata[GRP_W-1:0];
    end
  end

  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && !wr_val) |=> (cnt_q == $past(cnt_q) + 32'd1));
  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr && !wr_val) |=> $stable(cnt_q));
  assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_val && !clr) |=> (cnt_q == $past(wdata)));
  assert_wrap_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));
endmodule

// File: rtl/cpmu_cyc_ctr.sv
module cpmu_cyc_ctr
  import cpmu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_val,
  input  logic             wr_ctl,
  input  logic [CYC_W-1:0] wdata,
  input  logic             clr,
  input  logic             run,
  output logic [CYC_W-1:0] cyc_q,
  output logic [CNT_W-1:0] ctl_q,
  output logic             wrap
);
  logic [CYC_W-1:0] cyc_d;
  logic             cyc_ce;

  always_comb begin
    cyc_d = cyc_q;
    if (clr)         cyc_d = '0;
    else if (wr_val) cyc_d = wdata;
    else if (run)    cyc_d = cyc_q + 1'b1;
    cyc_ce = clr | wr_val | run;
    wrap   = run && !clr && !wr_val && (&cyc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      ctl_q <= '0;
    end else begin
      if (cyc_ce) cyc_q <= cyc_d;
      if (wr_ctl) ctl_q <= wdata[CNT_W-1:0];
    end
  end

  assert_cyc_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !wr_val) |=> (cyc_q == $past(cyc_q) + 64'd1));
  assert_cyc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr && !wr_val) |=> $stable(cyc_q));
endmodule

// File: rtl/cache_pmu.sv
module cache_pmu
  import cpmu_pkg::*;
#(
  parameter int NUM_CTR    = 8,
  parameter int NUM_GROUPS = 8,
  parameter int CODE_W     = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   acc_sel_we,
  input  logic [11:0]                            acc_sel_addr,
  input  logic                                   acc_wr_en,
  input  logic [63:0]                            acc_wdata,
  output logic [63:0]                            acc_rdata,
  input  logic [NUM_GROUPS*(1<<CODE_W)-1:0]      evt_pulse,
  output logic                                   pmu_irq
);
  localparam int NUM_CODES = 1 << CODE_W;
  localparam logic [MAP_W-1:0] PRESENT = present_mask(NUM_CTR);

  logic [ADDR_W-1:0] sel_q, sel_d;
  logic              run_q, run_d;
  logic [DATA_W-1:0] evsel_q, evsel_d;
  logic              wr_ctrl, wr_evsel, clr_gen, clr_cyc;
  logic [MAP_W-1:0]  cen_q, ien_q, ovf_q, ovf_evt;
  logic [NUM_GROUPS-1:0] hit_grp;
  logic [GRP_PAD-1:0]    hit_pad;
  logic [NUM_CTR-1:0]    ctr_wrap;
  logic [CNT_W-1:0]  ctr_val [NUM_CTR];
  logic [CNT_W-1:0]  ctr_ctl [NUM_CTR];
  logic [CNT_W-1:0]  ctr_flt [NUM_CTR];
  logic [GRP_W-1:0]  ctr_typ [NUM_CTR];
  logic [CYC_W-1:0]  cyc_val;
  logic [CNT_W-1:0]  cyc_ctl;
  logic              cyc_wrap;

  // access decode and next state
  always_comb begin
    sel_d    = acc_sel_addr;
    wr_ctrl  = acc_wr_en && (sel_q == A_CTRL);
    wr_evsel = acc_wr_en && (sel_q == A_EVSEL);
    run_d    = acc_wdata[0];
    clr_gen  = wr_ctrl && acc_wdata[1];
    clr_cyc  = wr_ctrl && acc_wdata[2];
    evsel_d  = acc_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      run_q   <= 1'b0;
      evsel_q <= '0;
    end else begin
      if (acc_sel_we) sel_q   <= sel_d;
      if (wr_ctrl)    run_q   <= run_d;
      if (wr_evsel)   evsel_q <= evsel_d;
    end
  end

  // per-group code selection
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic [NUM_CODES-1:0] grp_evts;
    logic [CODE_W-1:0]    code_sel;
    assign grp_evts   = evt_pulse[g*NUM_CODES +: NUM_CODES];
    assign code_sel   = evsel_q[g*CODE_W +: CODE_W];
    assign hit_grp[g] = evsel_q[DATA_W-1] && grp_evts[code_sel];
  end

  always_comb begin
    hit_pad = '0;
    hit_pad[NUM_GROUPS-1:0] = hit_grp;
  end

  // general counters
  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic page_hit;
    assign page_hit = acc_wr_en && (sel_q[11:4] == A_CTR_PG0 + 8'(i));
    cpmu_evt_ctr u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (page_hit),
      .wr_off  (sel_q[3:0]),
      .wdata   (acc_wdata[CNT_W-1:0]),
      .clr     (clr_gen),
      .run     (run_q && cen_q[i]),
      .grp_hit (hit_pad),
      .cnt_q   (ctr_val[i]),
      .ctl_q   (ctr_ctl[i]),
      .flt_q   (ctr_flt[i]),
      .typ_q   (ctr_typ[i]),
      .wrap    (ctr_wrap[i])
    );
  end

  cpmu_cyc_ctr u_cyc (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_val (acc_wr_en && (sel_q == A_CYC_VAL)),
    .wr_ctl (acc_wr_en && (sel_q == A_CYC_CTL)),
    .wdata  (acc_wdata),
    .clr    (clr_cyc),
    .run    (run_q && cen_q[CYC_BIT]),
    .cyc_q  (cyc_val),
    .ctl_q  (cyc_ctl),
    .wrap   (cyc_wrap)
  );

  always_comb begin
    ovf_evt = '0;
    ovf_evt[NUM_CTR-1:0] = ctr_wrap;
    ovf_evt[CYC_BIT] = cyc_wrap;
  end

  cpmu_bitmap #(.MASK(PRESENT)) u_cen (
    .clk(clk), .rst_n(rst_n),
    .set_we(acc_wr_en && (sel_q == A_CEN_SET)),
    .clr_we(acc_wr_en && (sel_q == A_CEN_CLR)),
    .wdata(acc_wdata[MAP_W-1:0]), .hw_set('0), .q(cen_q)
  );
  cpmu_bitmap #(.MASK(PRESENT)) u_ien (
    .clk(clk), .rst_n(rst_n),
    .set_we(acc_wr_en && (sel_q == A_IEN_SET)),
    .clr_we(acc_wr_en && (sel_q == A_IEN_CLR)),
    .wdata(acc_wdata[MAP_W-1:0]), .hw_set('0), .q(ien_q)
  );
  cpmu_bitmap #(.MASK(PRESENT)) u_ovf (
    .clk(clk), .rst_n(rst_n),
    .set_we(acc_wr_en && (sel_q == A_OVF_SET)),
    .clr_we(acc_wr_en && (sel_q == A_OVF_CLR)),
    .wdata(acc_wdata[MAP_W-1:0]), .hw_set(ovf_evt), .q(ovf_q)
  );

  // read window
  always_comb begin
    acc_rdata = '0;
    case (sel_q)
      A_CTRL: begin
        acc_rdata[0]     = run_q;
        acc_rdata[15:11] = 5'(NUM_CTR);
      end
      A_CEN_CLR, A_CEN_SET: acc_rdata = 64'(cen_q);
      A_IEN_CLR, A_IEN_SET: acc_rdata = 64'(ien_q);
      A_OVF_CLR, A_OVF_SET: acc_rdata = 64'(ovf_q);
      A_CYC_CTL:            acc_rdata = 64'(cyc_ctl);
      A_CYC_VAL:            acc_rdata = cyc_val;
      A_EVSEL:              acc_rdata = evsel_q;
      default: ;
    endcase
    for (int i = 0; i < NUM_CTR; i++) begin
      if (sel_q[11:4] == A_CTR_PG0 + 8'(i)) begin
        case (sel_q[3:0])
          O_CTL:   acc_rdata = 64'(ctr_ctl[i]);
          O_VAL:   acc_rdata = 64'(ctr_val[i]);
          O_FLT:   acc_rdata = 64'(ctr_flt[i]);
          O_TYP:   acc_rdata = 64'(ctr_typ[i]);
          default: ;
        endcase
      end
    end
  end

  assign pmu_irq = |(ovf_q & ien_q);

  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !pmu_irq);
  assert_ctrl_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_gen |=> (ctr_val[0] == '0));
  assert_cyc_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cyc |=> (cyc_val == '0));
endmodule

// File: tb/tb_cache_pmu.sv
module tb_cache_pmu;
  localparam int CLK_P = 10;
  localparam int NC    = 256;
  localparam int NG    = 8;

  logic        clk, rst_n;
  logic        acc_sel_we, acc_wr_en;
  logic [11:0] acc_sel_addr;
  logic [63:0] acc_wdata, acc_rdata;
  logic [NG*NC-1:0] evt_pulse;
  logic        pmu_irq;

  int n_chk, n_fail;
  bit done;

  cache_pmu dut (
    .clk(clk), .rst_n(rst_n), .acc_sel_we(acc_sel_we), .acc_sel_addr(acc_sel_addr),
    .acc_wr_en(acc_wr_en), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .evt_pulse(evt_pulse), .pmu_irq(pmu_irq)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [11:0] ctr_a(input int i, input int off);
    return 12'(12'h420 + i*16 + off);
  endfunction

  function automatic logic [7:0] code_of(input int g);
    return 8'h80 | 8'((g*29 + 3) & 127);
  endfunction

  function automatic logic [63:0] sel_word();
    logic [63:0] v;
    v = '0;
    for (int g = 0; g < NG; g++) v[g*8 +: 8] = code_of(g);
    v[63] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk); acc_sel_we = 1'b1; acc_sel_addr = a;
    @(negedge clk); acc_sel_we = 1'b0; acc_wr_en = 1'b1; acc_wdata = d;
    @(negedge clk); acc_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    @(negedge clk); acc_sel_we = 1'b1; acc_sel_addr = a;
    @(negedge clk); acc_sel_we = 1'b0; d = acc_rdata;
  endtask

  task automatic pulse(input int idx, input int n);
    @(negedge clk); evt_pulse[idx] = 1'b1;
    repeat (n) @(negedge clk);
    evt_pulse[idx] = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_P*150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [63:0] d, v;
    int exp0;
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; acc_sel_we = 0; acc_wr_en = 0; acc_sel_addr = '0; acc_wdata = '0;
    evt_pulse = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(12'h400, d); chk("R1 ctrl", d, 64'h4000);
    rd(12'h404, d); chk("R1 cen", d, 0);
    rd(12'h406, d); chk("R1 ien", d, 0);
    rd(12'h408, d); chk("R1 ovf", d, 0);
    rd(ctr_a(0,1), d); chk("R1 ctr0", d, 0);
    rd(12'h40A, d); chk("R1 cyc", d, 0);
    rd(12'h410, d); chk("R1 evsel", d, 0);
    chk("R1 irq", 64'(pmu_irq), 0);

    // R2 unmapped addresses
    wr(12'h401, 64'hFF); rd(12'h401, d); chk("R2 hole 401", d, 0);
    rd(12'h402, d); chk("R2 hole 402", d, 0);

    // R4 R5 set/clear pairs and mask
    wr(12'h404, 64'hFFFF_FFFF); rd(12'h404, d); chk("R4 R5 cen set mask", d, 64'h8000_00FF);
    rd(12'h403, d); chk("R4 cen via clr addr", d, 64'h8000_00FF);
    wr(12'h403, 64'h5); rd(12'h404, d); chk("R4 cen clear", d, 64'h8000_00FA);
    wr(12'h404, 64'h0); rd(12'h404, d); chk("R4 zero write no effect", d, 64'h8000_00FA);
    wr(12'h404, 64'h5); rd(12'h404, d); chk("R4 cen restore", d, 64'h8000_00FF);

    // R7 selection register
    v = sel_word();
    wr(12'h410, v); rd(12'h410, d); chk("R7 evsel readback", d, v);

    // R8 per-counter registers
    for (int i = 0; i < 8; i++) begin
      wr(ctr_a(i,0), 64'(32'hC0DE_0000 | i));
      wr(ctr_a(i,3), 64'(32'h000E_0007 ^ i));
      wr(ctr_a(i,4), 64'(12'hFF0 | i));
    end
    for (int i = 0; i < 8; i++) begin
      rd(ctr_a(i,0), d); chk("R8 ctl", d, 64'(32'hC0DE_0000 | i));
      rd(ctr_a(i,3), d); chk("R8 flt", d, 64'(32'h000E_0007 ^ i));
      rd(ctr_a(i,4), d); chk("R8 type 4-bit", d, 64'(i));
    end

    // R3 global enable gating before enable
    pulse(code_of(0), 2);
    rd(ctr_a(0,1), d); chk("R3 disabled no count", d, 0);

    // R6 sweep over groups
    wr(12'h400, 64'h1);
    for (int g = 0; g < NG; g++) begin
      pulse(g*NC + code_of(g), g+1);
      pulse(g*NC + (code_of(g) ^ 8'h01), 3);
    end
    for (int i = 0; i < 8; i++) begin
      rd(ctr_a(i,1), d); chk("R6 group sweep", d, 64'(i+1));
    end

    // R6 counter enable gating
    wr(12'h403, 64'h2); pulse(NC + code_of(1), 4);
    rd(ctr_a(1,1), d); chk("R6 cen off", d, 2);
    wr(12'h404, 64'h2);

    // R6 type outside groups
    wr(ctr_a(3,4), 64'h9); pulse(3*NC + code_of(3), 2);
    rd(ctr_a(3,1), d); chk("R6 type>=groups", d, 4);
    wr(ctr_a(3,4), 64'h3);

    // R6 R7 selection enable off
    wr(12'h410, v & ~(64'h1 << 63)); pulse(code_of(0), 2);
    rd(ctr_a(0,1), d); chk("R7 sel enable off", d, 1);

    // R7 code sweep on group 0
    exp0 = 1;
    for (int k = 0; k < 16; k++) begin
      logic [63:0] v2;
      logic [7:0] c;
      c = 8'(k*17);
      v2 = v; v2[7:0] = c;
      wr(12'h410, v2);
      pulse(int'(c), 1);
      pulse(int'(c ^ 8'h40), 1);
      exp0++;
    end
    rd(ctr_a(0,1), d); chk("R7 code sweep", d, 64'(exp0));

    // R7 group 7 top bit shared with enable
    v[63:56] = 8'h05; v[63] = 1'b1;
    wr(12'h410, v); pulse(7*NC + 8'h85, 1);
    rd(ctr_a(7,1), d); chk("R7 bit63 shared", d, 9);
    v = sel_word(); wr(12'h410, v);

    // R12 write beats increment
    @(negedge clk); acc_sel_we = 1'b1; acc_sel_addr = ctr_a(4,1);
    @(negedge clk); acc_sel_we = 1'b0; acc_wr_en = 1'b1; acc_wdata = 64'd100;
    evt_pulse[4*NC + code_of(4)] = 1'b1;
    @(negedge clk); acc_wr_en = 1'b0; evt_pulse = '0;
    rd(ctr_a(4,1), d); chk("R12 write wins", d, 100);
    pulse(4*NC + code_of(4), 1);
    rd(ctr_a(4,1), d); chk("R12 then counts", d, 101);

    // R10 R11 general wrap
    wr(ctr_a(2,1), 64'hFFFF_FFFE); pulse(2*NC + code_of(2), 3);
    rd(ctr_a(2,1), d); chk("R10 wrap value", d, 1);
    rd(12'h408, d); chk("R10 R5 ovf bit2", d, 64'h4);
    chk("R11 irq masked", 64'(pmu_irq), 0);
    wr(12'h406, 64'h4); chk("R11 irq on", 64'(pmu_irq), 1);
    wr(12'h407, 64'h4); chk("R11 irq off after clear", 64'(pmu_irq), 0);

    // R9 cycle counter window
    wr(12'h400, 64'h0); wr(12'h40A, 64'h0);
    wr(12'h400, 64'h1); repeat (5) @(negedge clk); wr(12'h400, 64'h0);
    rd(12'h40A, d); chk("R9 cycle count", d, 8);
    wr(12'h40A, 64'hFFFF_FFFF_FFFF_FFFE);
    wr(12'h400, 64'h1); wr(12'h400, 64'h0);
    rd(12'h40A, d); chk("R9 R10 cycle wrap", d, 1);
    rd(12'h408, d); chk("R10 R5 ovf bit31", d, 64'h8000_0000);
    chk("R11 cyc ovf masked", 64'(pmu_irq), 0);
    wr(12'h406, 64'h8000_0000); chk("R11 cyc irq", 64'(pmu_irq), 1);
    wr(12'h407, 64'h8000_0000); chk("R11 cyc irq clear", 64'(pmu_irq), 0);
    wr(12'h409, 64'h1234_5678); rd(12'h409, d); chk("R9 cyc ctl", d, 64'h1234_5678);

    // R4 software overflow set
    wr(12'h408, 64'hFFFF_FFFF); rd(12'h407, d); chk("R4 ovf set mask", d, 64'h8000_00FF);
    chk("R11 irq sw set", 64'(pmu_irq), 1);
    wr(12'h407, 64'hFFFF_FFFF); rd(12'h408, d); chk("R4 ovf clear all", d, 0);

    // R3 counter resets
    wr(12'h400, 64'h2);
    rd(ctr_a(0,1), d); chk("R3 gen reset ctr0", d, 0);
    rd(ctr_a(7,1), d); chk("R3 gen reset ctr7", d, 0);
    rd(12'h40A, d); chk("R3 cycle kept", d, 1);
    rd(12'h400, d); chk("R3 ctrl enable cleared", d, 64'h4000);
    wr(12'h400, 64'h4); rd(12'h40A, d); chk("R3 cycle reset", d, 0);
    wr(ctr_a(5,1), 64'h33); wr(12'h40A, 64'h44); wr(12'h400, 64'h6);
    rd(ctr_a(5,1), d); chk("R3 0x6 gen", d, 0);
    rd(12'h40A, d); chk("R3 0x6 cyc", d, 0);

    // R9 cycle enable bit gating
    wr(12'h403, 64'h8000_0000);
    wr(12'h400, 64'h1); repeat (4) @(negedge clk); wr(12'h400, 64'h0);
    rd(12'h40A, d); chk("R9 cyc bit off", d, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule